// File: doc/BRIEF.md
# Flash Operation State Controller

This block sits on the device side of a serial flash, behind the command shifter. Each time chip select returns high, the shifter presents the finished opcode together with a flag. The flag says whether chip select rose exactly after the eighth bit of the last byte. The controller tracks what the device is doing: idle, programming, writing the status byte, erasing a sector or block, erasing the whole chip, erase suspended, entering or sitting in power-down, or releasing from it. From that state it decides whether the command is taken up or dropped.

Self-timed operations are modelled with down-counters, and the busy flag is derived from the state. A sector or block erase keeps its remaining time in its own counter. That counter freezes while the erase is suspended, so a program may run in the meantime, and it continues from the saved count when the erase resumes. Power-down listens only to the release opcode. Every length is a parameter, counted in clock cycles.

Top module: `flash_op_ctrl`

## Requirements
- R1: After reset, state_o is 0 (idle), busy_o is 0 and neither accept_o nor reject_o is set. State codes: 0 idle, 1 program, 2 status write, 3 sector/block erase, 4 chip erase, 5 suspend pending, 6 suspended, 7 program while suspended, 8 power-down entry, 9 power-down, 10 release.
- R2: For each cycle with cmd_valid_i high, exactly one of accept_o or reject_o is high in the following cycle. Neither is high in any other cycle.
- R3: In idle, the following commands start only when wel_i and aligned_i are both 1: 01h, program (02h, 32h), sector erase 20h, block erase (52h, D8h) and chip erase (C7h, 60h). Program and erase also need prot_hit_i at 0, and chip erase needs any_prot_i at 0. Reads (03h, 0Bh, 3Bh, 6Bh, BBh, EBh), status reads (05h, 35h), 06h, 04h and ABh are accepted in idle without changing state.
- R4: Once started, busy_o stays 1 for exactly T_PROG, T_WRSR, T_SE, T_BE or T_CE cycles, after which state_o returns to 0.
- R5: While busy_o is 1, only 05h and 35h are accepted. Everything else is rejected, data read 03h and ABh included, and the remaining time of the running operation is unchanged.
- R6: 75h is accepted only during a sector or block erase that is not in its final cycle. It is rejected in idle and during chip erase, program or status write. When accepted, busy_o stays 1 for T_SUS cycles, then falls to 0 with state 6.
- R7: While suspended, 01h, 20h, 52h, D8h, C7h, 60h, 75h and B9h are rejected. Reads, status reads, 06h, 04h and ABh are accepted. A program passing the R3 conditions runs for T_PROG cycles and then returns to state 6.
- R8: 7Ah in state 6 resumes the erase with busy_o at 1 for the remaining time: the erase length minus the cycles already spent erasing. In every other state 7Ah is rejected.
- R9: B9h with aligned_i set enters state 8 for T_DP cycles, then state 9. In states 8 and 9 every opcode is rejected, status reads included, except ABh in state 9.
- R10: ABh in state 9 enters state 10 for T_RES cycles, with every opcode rejected, then state 0.
- R11: Opcodes not named in R3 to R10 are rejected in every state and leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | One-cycle pulse: a command has ended |
| opcode_i | input | 8 | Opcode of the ended command |
| aligned_i | input | 1 | Chip select rose right after the 8th bit of the last byte |
| wel_i | input | 1 | Write-enable latch |
| prot_hit_i | input | 1 | Addressed region is write-protected |
| any_prot_i | input | 1 | Some region is write-protected |
| accept_o | output | 1 | Command accepted (one cycle after cmd_valid_i) |
| reject_o | output | 1 | Command ignored (one cycle after cmd_valid_i) |
| busy_o | output | 1 | Self-timed operation in progress |
| state_o | output | 4 | Operating state code |

## Verification
The bench suspends a sector erase part way through and then resumes it, measuring that the erase time left over is the original length minus the cycles already spent. A counter that kept running or reloaded on resume would give a different busy length. It runs a program in the middle of the suspension and fires random opcodes while a chip erase runs, then checks that the chip erase still ends on time and that only status reads got through. A design that let 75h stop a chip erase, or let a data read disturb the count, would fail here. It also checks misaligned, unlatched and protected program and erase requests in idle, and sends random opcodes into power-down, where a design that answered status reads or skipped the entry or release delay would show up.

// File: rtl/flash_opc_pkg.sv
package flash_opc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_PROG      = 4'd1,
    ST_WRSR      = 4'd2,
    ST_ERASE     = 4'd3,
    ST_CHIP      = 4'd4,
    ST_SUSP_WAIT = 4'd5,
    ST_SUSP      = 4'd6,
    ST_SUSP_PROG = 4'd7,
    ST_PD_ENTER  = 4'd8,
    ST_PD        = 4'd9,
    ST_RELEASE   = 4'd10
  } fst_e;

  typedef enum logic [3:0] {
    CL_OTHER, CL_RDSR, CL_READ, CL_WEN, CL_WRSR, CL_PROG, CL_SE,
    CL_BE, CL_CE, CL_SUSP, CL_RESUME, CL_PD, CL_REL
  } cls_e;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_WRSR, ACT_PROG, ACT_SE, ACT_BE, ACT_CE,
    ACT_SUSP, ACT_RESUME, ACT_PD, ACT_REL
  } act_e;

  localparam int LN_OP = 0;
  localparam int LN_ER = 1;
  localparam int NLANE = 2;

  function automatic cls_e classify(input logic [7:0] opc);
    case (opc)
      8'h05, 8'h35:                             return CL_RDSR;
      8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB: return CL_READ;
      8'h06, 8'h04:                             return CL_WEN;
      8'h01:                                    return CL_WRSR;
      8'h02, 8'h32:                             return CL_PROG;
      8'h20:                                    return CL_SE;
      8'h52, 8'hD8:                             return CL_BE;
      8'hC7, 8'h60:                             return CL_CE;
      8'h75:                                    return CL_SUSP;
      8'h7A:                                    return CL_RESUME;
      8'hB9:                                    return CL_PD;
      8'hAB:                                    return CL_REL;
      default:                                  return CL_OTHER;
    endcase
  endfunction

  function automatic logic is_busy_st(input fst_e s);
    return (s == ST_PROG) || (s == ST_WRSR) || (s == ST_ERASE) ||
           (s == ST_CHIP) || (s == ST_SUSP_WAIT) || (s == ST_SUSP_PROG);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fop_cnt.sv
module fop_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         run_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= len_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign last_o = (cnt_q == W'(1));

  // R4
  cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |-> (cnt_q != '0));

  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fop_gate.sv
module fop_gate
  import flash_opc_pkg::*;
(
  input  fst_e state_i,
  input  cls_e cls_i,
  input  logic wel_i,
  input  logic aligned_i,
  input  logic prot_hit_i,
  input  logic any_prot_i,
  input  logic er_last_i,
  output logic ok_o,
  output act_e act_o
);
  logic wr_ok, pe_ok;
  act_e tgt;

  assign wr_ok = wel_i & aligned_i;
  assign pe_ok = wr_ok & ~prot_hit_i;

  always_comb begin
    ok_o = 1'b0;
    tgt  = ACT_NONE;
    case (state_i)
      ST_IDLE: begin
        case (cls_i)
          CL_RDSR, CL_READ, CL_WEN, CL_REL: ok_o = 1'b1;
          CL_WRSR: begin ok_o = wr_ok;                  tgt = ACT_WRSR; end
          CL_PROG: begin ok_o = pe_ok;                  tgt = ACT_PROG; end
          CL_SE:   begin ok_o = pe_ok;                  tgt = ACT_SE;   end
          CL_BE:   begin ok_o = pe_ok;                  tgt = ACT_BE;   end
          CL_CE:   begin ok_o = wr_ok & ~any_prot_i;    tgt = ACT_CE;   end
          CL_PD:   begin ok_o = aligned_i;              tgt = ACT_PD;   end
          default: ok_o = 1'b0;
        endcase
      end
      ST_ERASE: begin
        if (cls_i == CL_RDSR) ok_o = 1'b1;
        else if (cls_i == CL_SUSP && !er_last_i) begin
          ok_o = 1'b1;
          tgt  = ACT_SUSP;
        end
      end
      ST_PROG, ST_WRSR, ST_CHIP, ST_SUSP_WAIT, ST_SUSP_PROG:
        ok_o = (cls_i == CL_RDSR);
      ST_SUSP: begin
        case (cls_i)
          CL_RDSR, CL_READ, CL_WEN, CL_REL: ok_o = 1'b1;
          CL_PROG:   begin ok_o = pe_ok; tgt = ACT_PROG;   end
          CL_RESUME: begin ok_o = 1'b1;  tgt = ACT_RESUME; end
          default:   ok_o = 1'b0;
        endcase
      end
      ST_PD: begin
        if (cls_i == CL_REL) begin
          ok_o = 1'b1;
          tgt  = ACT_REL;
        end
      end
      default: ok_o = 1'b0;
    endcase
    act_o = ok_o ? tgt : ACT_NONE;
  end
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
  import flash_opc_pkg::*;
#(
  parameter int T_PROG = 12,
  parameter int T_WRSR = 10,
  parameter int T_SE   = 40,
  parameter int T_BE   = 60,
  parameter int T_CE   = 300,
  parameter int T_SUS  = 4,
  parameter int T_DP   = 3,
  parameter int T_RES  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] opcode_i,
  input  logic       aligned_i,
  input  logic       wel_i,
  input  logic       prot_hit_i,
  input  logic       any_prot_i,
  output logic       accept_o,
  output logic       reject_o,
  output logic       busy_o,
  output logic [3:0] state_o
);
  localparam int T_MAX = imax(imax(imax(T_PROG, T_WRSR), imax(T_SE, T_BE)),
                              imax(imax(T_CE, T_SUS), imax(T_DP, T_RES)));
  localparam int CW = $clog2(T_MAX + 1);

  fst_e state_q, state_d;
  cls_e cls;
  act_e act;
  logic ok, take, accept_q, reject_q;
  logic [NLANE-1:0] c_load, c_run, c_last;
  logic [CW-1:0]    c_len [NLANE];

  assign cls  = classify(opcode_i);
  assign take = cmd_valid_i & ok;

  fop_gate u_gate (
    .state_i    (state_q),
    .cls_i      (cls),
    .wel_i      (wel_i),
    .aligned_i  (aligned_i),
    .prot_hit_i (prot_hit_i),
    .any_prot_i (any_prot_i),
    .er_last_i  (c_last[LN_ER]),
    .ok_o       (ok),
    .act_o      (act)
  );

  always_comb begin
    state_d       = state_q;
    c_load        = '0;
    c_len[LN_OP]  = '0;
    c_len[LN_ER]  = '0;
    if (take && act != ACT_NONE) begin
      case (act)
        ACT_WRSR: begin state_d = ST_WRSR;  c_load[LN_OP] = 1'b1; c_len[LN_OP] = CW'(T_WRSR); end
        ACT_PROG: begin
          state_d       = (state_q == ST_SUSP) ? ST_SUSP_PROG : ST_PROG;
          c_load[LN_OP] = 1'b1;
          c_len[LN_OP]  = CW'(T_PROG);
        end
        ACT_SE:     begin state_d = ST_ERASE;     c_load[LN_ER] = 1'b1; c_len[LN_ER] = CW'(T_SE);  end
        ACT_BE:     begin state_d = ST_ERASE;     c_load[LN_ER] = 1'b1; c_len[LN_ER] = CW'(T_BE);  end
        ACT_CE:     begin state_d = ST_CHIP;      c_load[LN_OP] = 1'b1; c_len[LN_OP] = CW'(T_CE);  end
        ACT_SUSP:   begin state_d = ST_SUSP_WAIT; c_load[LN_OP] = 1'b1; c_len[LN_OP] = CW'(T_SUS); end
        ACT_RESUME: state_d = ST_ERASE;
        ACT_PD:     begin state_d = ST_PD_ENTER;  c_load[LN_OP] = 1'b1; c_len[LN_OP] = CW'(T_DP);  end
        ACT_REL:    begin state_d = ST_RELEASE;   c_load[LN_OP] = 1'b1; c_len[LN_OP] = CW'(T_RES); end
        default:    state_d = state_q;
      endcase
    end else begin
      case (state_q)
        ST_PROG, ST_WRSR, ST_CHIP, ST_RELEASE:
          if (c_last[LN_OP]) state_d = ST_IDLE;
        ST_SUSP_WAIT, ST_SUSP_PROG:
          if (c_last[LN_OP]) state_d = ST_SUSP;
        ST_PD_ENTER:
          if (c_last[LN_OP]) state_d = ST_PD;
        ST_ERASE:
          if (c_last[LN_ER]) state_d = ST_IDLE;
        default: state_d = state_q;
      endcase
    end
  end

  assign c_run[LN_OP] = (state_q == ST_PROG) || (state_q == ST_WRSR) ||
                        (state_q == ST_CHIP) || (state_q == ST_SUSP_WAIT) ||
                        (state_q == ST_SUSP_PROG) || (state_q == ST_PD_ENTER) ||
                        (state_q == ST_RELEASE);
  // erase time advances only in the erase state; frozen across suspend
  assign c_run[LN_ER] = (state_q == ST_ERASE);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    fop_cnt #(.W(CW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (c_load[g]),
      .len_i  (c_len[g]),
      .run_i  (c_run[g]),
      .last_o (c_last[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      accept_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      accept_q <= cmd_valid_i & ok;
      reject_q <= cmd_valid_i & ~ok;
    end
  end

  assign accept_o = accept_q;
  assign reject_o = reject_q;
  assign busy_o   = is_busy_st(state_q);
  assign state_o  = state_q;

  // R2
  dec_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o));

  // R2
  dec_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (accept_o ^ reject_o));

  // R5
  busy_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i && opcode_i == 8'h03) |=> reject_o);

  // R6
  chip_nosusp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHIP && cmd_valid_i && opcode_i == 8'h75) |=> reject_o);

  // R7
  susp_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && cmd_valid_i &&
     (opcode_i == 8'h20 || opcode_i == 8'hD8 || opcode_i == 8'hC7 || opcode_i == 8'h01))
    |=> (reject_o && state_q == ST_SUSP));

  // R8
  resume_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && cmd_valid_i && opcode_i == 8'h7A) |=> busy_o);

  // R9
  pd_filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD && cmd_valid_i && opcode_i != 8'hAB) |=> (reject_o && state_q == ST_PD));
endmodule

// File: tb/flash_op_ctrl_bench.sv
module flash_op_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_PROG = 12, T_WRSR = 10, T_SE = 40, T_BE = 60;
  localparam int T_CE = 300, T_SUS = 4, T_DP = 3, T_RES = 5;
  localparam int NOPS = 26;
  localparam logic [7:0] OPS [NOPS] = '{
    8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'h05, 8'h35, 8'h06, 8'h04,
    8'h01, 8'h02, 8'h32, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h75, 8'h7A,
    8'hB9, 8'hAB, 8'hA3, 8'h9F, 8'h00, 8'hFF};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, aligned = 1'b0, wel = 1'b0, prot_hit = 1'b0, any_prot = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic accept, reject, busy;
  logic [3:0] state;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;
  logic s_acc, s_rej, s_busy;
  logic [3:0] s_state;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_op_ctrl #(
    .T_PROG(T_PROG), .T_WRSR(T_WRSR), .T_SE(T_SE), .T_BE(T_BE),
    .T_CE(T_CE), .T_SUS(T_SUS), .T_DP(T_DP), .T_RES(T_RES)
  ) u_flash_op_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .opcode_i(opcode),
    .aligned_i(aligned), .wel_i(wel), .prot_hit_i(prot_hit), .any_prot_i(any_prot),
    .accept_o(accept), .reject_o(reject), .busy_o(busy), .state_o(state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the decision sampled
  task automatic issue(input logic [7:0] o, input bit w, input bit a, input bit ph, input bit ap);
    opcode = o; wel = w; aligned = a; prot_hit = ph; any_prot = ap;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    s_acc = accept; s_rej = reject; s_busy = busy; s_state = state;
  endtask

  // decision code: 2 = accepted only, 1 = rejected only
  function automatic int dec(input bit acc_exp);
    return acc_exp ? 2 : 1;
  endfunction

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic count_state(input logic [3:0] s, output int n);
    n = 0;
    while (state == s && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_state(input logic [3:0] s);
    int g = 0;
    while (state != s && g < 2000) begin g++; @(negedge clk); end
  endtask

  function automatic bit is_read(input logic [7:0] o);
    return o == 8'h03 || o == 8'h0B || o == 8'h3B || o == 8'h6B || o == 8'hBB ||
           o == 8'hEB || o == 8'h05 || o == 8'h35 || o == 8'h06 || o == 8'h04 || o == 8'hAB;
  endfunction

  function automatic bit exp_idle(input logic [7:0] o, input bit w, input bit a, input bit ph, input bit ap);
    if (is_read(o)) return 1'b1;
    case (o)
      8'h01:                             return w & a;
      8'h02, 8'h32, 8'h20, 8'h52, 8'hD8: return w & a & ~ph;
      8'hC7, 8'h60:                      return w & a & ~ap;
      8'hB9:                             return a;
      default:                           return 1'b0;
    endcase
  endfunction

  function automatic bit exp_susp(input logic [7:0] o, input bit w, input bit a, input bit ph);
    if (is_read(o)) return 1'b1;
    case (o)
      8'h02, 8'h32: return w & a & ~ph;
      8'h7A:        return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

  function automatic bit exp_busy(input logic [7:0] o);
    return o == 8'h05 || o == 8'h35;
  endfunction

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int n, m, k;
    logic [7:0] o;
    bit w, a, ph, ap;
    void'($urandom(32'h1D2C3B4A));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 reset state", state, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset accept", accept, 0);
    chk("R1 reset reject", reject, 0);

    // program timing
    issue(8'h02, 1, 1, 0, 0);
    chk("R3 program accept", dec(1), {s_acc, s_rej});
    chk("R4 program state", s_state, 1);
    count_busy(n);
    chk("R4 program busy length", n, T_PROG);
    chk("R4 idle after program", state, 0);
    chk("R2 no decision without command", {accept, reject}, 0);

    issue(8'h01, 1, 1, 1, 1);
    chk("R3 status write accept", {s_acc, s_rej}, dec(1));
    count_busy(n);
    chk("R4 status write length", n, T_WRSR);

    issue(8'hD8, 1, 1, 0, 0);
    chk("R4 block erase state", s_state, 3);
    count_busy(n);
    chk("R4 block erase length", n, T_BE);

    issue(8'h20, 1, 0, 0, 0);
    chk("R3 misaligned erase rejected", {s_acc, s_rej}, dec(0));
    chk("R3 misaligned erase state", s_state, 0);
    issue(8'h02, 0, 1, 0, 0);
    chk("R3 no latch program rejected", {s_acc, s_rej}, dec(0));
    issue(8'h52, 1, 1, 1, 0);
    chk("R3 protected erase rejected", {s_acc, s_rej}, dec(0));
    issue(8'hC7, 1, 1, 0, 1);
    chk("R3 chip erase any-protect rejected", {s_acc, s_rej}, dec(0));
    chk("R3 state idle after rejects", s_state, 0);
    issue(8'h75, 1, 1, 0, 0);
    chk("R6 suspend in idle rejected", {s_acc, s_rej}, dec(0));
    issue(8'h7A, 1, 1, 0, 0);
    chk("R8 resume in idle rejected", {s_acc, s_rej}, dec(0));
    issue(8'hA3, 1, 1, 0, 0);
    chk("R11 unknown opcode rejected", {s_acc, s_rej}, dec(0));

    // chip erase with random traffic
    issue(8'h60, 1, 1, 1, 0);
    chk("R3 chip erase ignores region hit", {s_acc, s_rej}, dec(1));
    chk("R4 chip erase state", s_state, 4);
    k = 1;
    for (int i = 0; i < 60; i++) begin
      o = OPS[$urandom % NOPS];
      issue(o, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      chk($sformatf("R5 busy filter op %02h", o), {s_acc, s_rej}, dec(exp_busy(o)));
      k += s_busy;
    end
    chk("R6 chip erase not suspended", state, 4);
    @(negedge clk);
    count_busy(n);
    chk("R5 chip erase length unchanged", k + n, T_CE);

    // suspend ignored during program
    issue(8'h32, 1, 1, 0, 0);
    issue(8'h75, 1, 1, 0, 0);
    chk("R6 suspend during program rejected", {s_acc, s_rej}, dec(0));
    count_busy(n);
    chk("R6 program length with suspend attempt", 1 + n, T_PROG);

    // suspend and resume of a sector erase
    issue(8'h20, 1, 1, 0, 0);
    repeat (9) @(negedge clk);
    issue(8'h75, 1, 1, 0, 0);
    chk("R6 suspend accepted", {s_acc, s_rej}, dec(1));
    chk("R6 suspend pending state", s_state, 5);
    count_busy(n);
    chk("R6 suspend latency", n, T_SUS);
    chk("R6 suspended state", state, 6);
    for (int i = 0; i < 40; i++) begin
      do o = OPS[$urandom % NOPS]; while (o == 8'h7A || o == 8'h02 || o == 8'h32);
      issue(o, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      chk($sformatf("R7 suspend filter op %02h", o), {s_acc, s_rej}, dec(exp_susp(o, 0, 0, 0)));
    end
    chk("R7 still suspended", state, 6);
    issue(8'h02, 1, 1, 0, 0);
    chk("R7 program in suspend accepted", {s_acc, s_rej}, dec(1));
    chk("R7 program in suspend state", s_state, 7);
    count_busy(n);
    chk("R7 program in suspend length", n, T_PROG);
    chk("R7 back to suspended", state, 6);
    issue(8'h02, 1, 1, 1, 0);
    chk("R7 protected program in suspend rejected", {s_acc, s_rej}, dec(0));
    issue(8'h7A, 0, 0, 0, 0);
    chk("R8 resume accepted", {s_acc, s_rej}, dec(1));
    chk("R8 resume state", s_state, 3);
    count_busy(n);
    chk("R8 remaining erase time", n, T_SE - 10);
    chk("R8 idle after resumed erase", state, 0);

    // power-down
    issue(8'hB9, 0, 0, 0, 0);
    chk("R9 misaligned power-down rejected", {s_acc, s_rej}, dec(0));
    issue(8'hB9, 0, 1, 0, 0);
    chk("R9 power-down accepted", {s_acc, s_rej}, dec(1));
    count_state(4'd8, n);
    chk("R9 power-down entry delay", n, T_DP);
    chk("R9 power-down state", state, 9);
    for (int i = 0; i < 20; i++) begin
      do o = OPS[$urandom % NOPS]; while (o == 8'hAB);
      issue(o, 1, 1, 0, 0);
      chk($sformatf("R9 power-down ignores op %02h", o), {s_acc, s_rej}, dec(0));
    end
    chk("R9 remains in power-down", state, 9);
    issue(8'hAB, 0, 0, 0, 0);
    chk("R10 release accepted", {s_acc, s_rej}, dec(1));
    chk("R10 release state", s_state, 10);
    issue(8'h05, 0, 0, 0, 0);
    chk("R10 status read during release rejected", {s_acc, s_rej}, dec(0));
    count_state(4'd10, n);
    chk("R10 release delay", 1 + n, T_RES);
    chk("R10 idle after release", state, 0);

    // random idle traffic
    for (int i = 0; i < 60; i++) begin
      o  = OPS[$urandom % NOPS];
      w  = ($urandom % 4) != 0;
      a  = ($urandom % 5) != 0;
      ph = ($urandom % 4) == 0;
      ap = ($urandom % 4) == 0;
      issue(o, w, a, ph, ap);
      chk($sformatf("R3 idle decision op %02h", o), {s_acc, s_rej}, dec(exp_idle(o, w, a, ph, ap)));
      if (o == 8'hB9 && s_acc) begin
        wait_state(4'd9);
        issue(8'hAB, 0, 0, 0, 0);
        chk("R10 release after random power-down", {s_acc, s_rej}, dec(1));
      end
      wait_state(4'd0);
      chk($sformatf("R11 idle after op %02h", o), state, 0);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule